// File: doc/BRIEF.md
# Bus Master Transfer Sequencer

This block is the master-side sequencer that performs a single read or write on a shared parallel system bus once the bus has already been won by arbitration. Local logic hands it a request made of an address, a write word, a memory-or-I/O select and a read-or-write select. The sequencer then drives the address, and the data on a write, for a minimum setup window. Next it pulls low exactly one of four active-low command strobes and waits for the addressed slave to pull its acknowledge low. It then releases the strobe and keeps the address for a minimum hold window. Finally it reports completion with a one-cycle done pulse, together with the read word and an error flag.

The slave acknowledge is asynchronous to the local clock. It passes through a two-flop synchronizer before the state machine acts on it, so a transfer lasts as long as the slave takes to answer and has no fixed length. Setup and hold windows are given in nanoseconds and converted to local-clock cycles, rounded up. A timeout bounds the wait for a slave that never answers. The states are ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD and ST_DONE. The transitions are: IDLE to SETUP on an accepted request; SETUP to STROBE when the setup count expires; STROBE to HOLD on the synchronized acknowledge or on timeout; HOLD to DONE when the hold count expires; DONE to IDLE unconditionally.

Top module: `bxfer_seq`

## Requirements
- R1: After reset all four strobes are high, req_ready is 1, rsp_done is 0 and bus_data_oe is 0.
- R2: req_ready is 1 only in the idle state. A request (req_valid high at a rising edge) is taken only while req_ready is 1, and a request presented at any other time leaves bus_addr unchanged and starts nothing.
- R3: After a request is taken, bus_addr carries the request address for exactly SETUP_CYC = ceil(SETUP_NS*1000/CLK_PERIOD_PS) cycles (3 by default) before a strobe goes low.
- R4: Exactly one strobe is low during the command phase. The selection is: req_io=0,req_wr=0 gives mrd_n; req_io=0,req_wr=1 gives mwr_n; req_io=1,req_wr=0 gives iord_n; req_io=1,req_wr=1 gives iowr_n.
- R5: The strobe returns high at the third rising clock edge after xack_n is seen low, so an acknowledge applied d cycles into the command phase gives a command phase of d+3 cycles.
- R6: On a read, the bus_data_in word present at the edge that ends the command phase is returned on rsp_rdata during the done pulse.
- R7: After the strobe returns high, bus_addr stays unchanged for HOLD_CYC = ceil(HOLD_NS*1000/CLK_PERIOD_PS) cycles (3 by default), and then rsp_done is high for one cycle.
- R8: If no acknowledge arrives, the strobe is released after TMO_CYCLES cycles of command phase, the hold window still applies, and rsp_err is 1 during the done pulse.
- R9: bus_addr does not change while a strobe is low. On a write, bus_data_oe is 1 and bus_data_out carries the write word from the setup phase onward.
- R10: rsp_done is never high for two cycles in a row, and rsp_err is 0 for a transfer that was acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transfer request |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write word |
| req_io | input | 1 | 1 selects I/O space, 0 memory |
| req_wr | input | 1 | 1 selects write, 0 read |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| bus_addr | output | ADDR_W | Address to the bus drivers |
| bus_data_out | output | DATA_W | Write data to the bus drivers |
| bus_data_oe | output | 1 | Enables the data drivers on a write |
| bus_data_in | input | DATA_W | Data from the bus receivers |
| mrd_n | output | 1 | Memory read strobe, active low |
| mwr_n | output | 1 | Memory write strobe, active low |
| iord_n | output | 1 | I/O read strobe, active low |
| iowr_n | output | 1 | I/O write strobe, active low |
| xack_n | input | 1 | Asynchronous slave acknowledge, active low |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read word, valid with rsp_done |
| rsp_err | output | 1 | Timeout flag, valid with rsp_done |

## Verification
The bench measures the setup, command and hold phases in whole cycles. A sequencer that counted one cycle short or long would strobe before the address had settled, or would drop the address too early, and the measured length would differ from the rounded-up value. It applies the acknowledge in the first command cycle and at later random points, so a synchronizer with the wrong depth, or data captured one edge late, shows up as a wrong command length or a stale read word. A slave that never answers checks that the timeout still releases the strobe, keeps the hold window and raises the error flag. Requests held high throughout a transfer check that a busy sequencer does not restart or move its address.

// File: rtl/bxfer_pkg.sv
package bxfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } xfer_state_t;

    // bit 1 = I/O space, bit 0 = write
    typedef enum logic [1:0] {
        CMD_MRD  = 2'd0,
        CMD_MWR  = 2'd1,
        CMD_IORD = 2'd2,
        CMD_IOWR = 2'd3
    } xfer_cmd_t;

    // nanoseconds to local-clock cycles, rounded up, at least one
    function automatic int ns_to_cycles(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/bxfer_sync.sv
module bxfer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/bxfer_timer.sv
module bxfer_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/bxfer_strobe.sv
module bxfer_strobe (
    input  logic                 active,
    input  bxfer_pkg::xfer_cmd_t cmd,
    output logic [3:0]           strobe_n
);
    // strobe_n index equals the command code
    for (genvar g = 0; g < 4; g++) begin : g_strobe
        assign strobe_n[g] = !(active && (cmd == bxfer_pkg::xfer_cmd_t'(g)));
    end
endmodule

// File: rtl/bxfer_seq.sv
module bxfer_seq #(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_PS = 20000,
    parameter int SETUP_NS      = 50,
    parameter int HOLD_NS       = 50,
    parameter int TMO_CYCLES    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_io,
    input  logic              req_wr,
    output logic              req_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic              mrd_n,
    output logic              mwr_n,
    output logic              iord_n,
    output logic              iowr_n,
    input  logic              xack_n,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    import bxfer_pkg::*;

    localparam int SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_PERIOD_PS);
    localparam int HOLD_CYC  = ns_to_cycles(HOLD_NS, CLK_PERIOD_PS);
    localparam int TMO_CYC   = (TMO_CYCLES < 1) ? 1 : TMO_CYCLES;
    localparam int WIN_MAX   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int TMR_MAX   = (WIN_MAX > TMO_CYC) ? WIN_MAX : TMO_CYC;
    localparam int TMR_W     = $clog2(TMR_MAX + 1);

    xfer_state_t state, state_nx;
    xfer_cmd_t   cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    logic              ack_s;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              take_req;
    logic              ack_edge;
    logic              tmo_edge;
    logic              strobe_on;
    logic [3:0]        strobe_n;

    bxfer_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(!xack_n),
        .sync_out(ack_s)
    );

    bxfer_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_done)
    );

    bxfer_strobe u_strobe (
        .active  (strobe_on),
        .cmd     (cmd_q),
        .strobe_n(strobe_n)
    );

    // next-state and timer control
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        take_req = 1'b0;
        ack_edge = 1'b0;
        tmo_edge = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    take_req = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SETUP_CYC - 1);
                    state_nx = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(TMO_CYC - 1);
                    state_nx = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (ack_s) begin
                    ack_edge = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(HOLD_CYC - 1);
                    state_nx = ST_HOLD;
                end else if (tmr_done) begin
                    tmo_edge = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(HOLD_CYC - 1);
                    state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    state_nx = ST_DONE;
                end
            end
            ST_DONE: begin
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transfer context and captured results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            cmd_q   <= CMD_MRD;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (take_req) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                cmd_q   <= xfer_cmd_t'({req_io, req_wr});
                err_q   <= 1'b0;
            end
            if (ack_edge && !cmd_q[0]) begin
                rdata_q <= bus_data_in;
            end
            if (tmo_edge) begin
                err_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state == ST_IDLE);
        strobe_on    = (state == ST_STROBE);
        bus_addr     = addr_q;
        bus_data_out = wdata_q;
        bus_data_oe  = cmd_q[0] && ((state == ST_SETUP) || (state == ST_STROBE) ||
                                    (state == ST_HOLD));
        mrd_n        = strobe_n[CMD_MRD];
        mwr_n        = strobe_n[CMD_MWR];
        iord_n       = strobe_n[CMD_IORD];
        iowr_n       = strobe_n[CMD_IOWR];
        rsp_done     = (state == ST_DONE);
        rsp_rdata    = rdata_q;
        rsp_err      = (state == ST_DONE) && err_q;
    end

endmodule

// File: rtl/bxfer_chk.sv
module bxfer_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_data_oe,
    input logic              mrd_n,
    input logic              mwr_n,
    input logic              iord_n,
    input logic              iowr_n,
    input logic              rsp_done
);
    logic [3:0] act;
    logic       any_on;
    assign act    = ~{iowr_n, iord_n, mwr_n, mrd_n};
    assign any_on = |act;

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act) <= 1);

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_on && $past(any_on)) |-> $stable(bus_addr));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!any_on && !bus_data_oe));

    assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_on) |-> !$past(req_ready));

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !any_on);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind bxfer_seq bxfer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .bus_addr   (bus_addr),
    .bus_data_oe(bus_data_oe),
    .mrd_n      (mrd_n),
    .mwr_n      (mwr_n),
    .iord_n     (iord_n),
    .iowr_n     (iowr_n),
    .rsp_done   (rsp_done)
);

// File: tb/test_bxfer_seq.sv
`timescale 1ns/1ps
module test_bxfer_seq;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int PERIOD_PS = 20000;
    localparam int SET_NS = 50;
    localparam int HLD_NS = 50;
    localparam int TMO = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_io = 1'b0;
    logic req_wr = 1'b0;
    logic req_ready;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data_out;
    logic bus_data_oe;
    logic [DW-1:0] bus_data_in = '0;
    logic mrd_n, mwr_n, iord_n, iowr_n;
    logic xack_n = 1'b1;
    logic rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic rsp_err;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bxfer_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_PS(PERIOD_PS),
                .SETUP_NS(SET_NS), .HOLD_NS(HLD_NS), .TMO_CYCLES(TMO)) i_bxfer_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_io(req_io), .req_wr(req_wr), .req_ready(req_ready),
        .bus_addr(bus_addr), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .bus_data_in(bus_data_in), .mrd_n(mrd_n), .mwr_n(mwr_n), .iord_n(iord_n),
        .iowr_n(iowr_n), .xack_n(xack_n), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err)
    );

    function automatic int exp_cycles(input int ns);
        int c;
        c = (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
        return (c < 1) ? 1 : c;
    endfunction

    // expected {iowr_n, iord_n, mwr_n, mrd_n}
    function automatic logic [3:0] exp_strobes(input logic io, input logic wr);
        logic [3:0] v;
        v = 4'b1111;
        v[{io, wr}] = 1'b0;
        return v;
    endfunction

    function automatic logic [3:0] strobes();
        return {iowr_n, iord_n, mwr_n, mrd_n};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic xfer(input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic io,
                        input logic wr, input int dly, input bit noack, input bit junk);
        int n;
        bit addr_ok;
        bit data_ok;
        logic [DW-1:0] rd;
        rd = DW'($urandom);
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready in idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_addr = a; req_wdata = wd; req_io = io; req_wr = wr;
        @(negedge clk);
        if (junk) begin
            req_addr = ~a; req_wdata = ~wd; req_io = ~io;
            check(req_ready == 1'b0, "R2 busy not ready", 32'(req_ready), 0);
        end else begin
            req_valid = 1'b0;
        end
        // setup phase
        n = 0; addr_ok = 1'b1; data_ok = 1'b1;
        while (strobes() == 4'b1111 && n < 200) begin
            if (bus_addr !== a) addr_ok = 1'b0;
            if (wr && (bus_data_oe !== 1'b1 || bus_data_out !== wd)) data_ok = 1'b0;
            if (!wr && bus_data_oe !== 1'b0) data_ok = 1'b0;
            n++;
            @(negedge clk);
        end
        check(n == exp_cycles(SET_NS), "R3 setup length", 32'(n), 32'(exp_cycles(SET_NS)));
        check(addr_ok, "R3 address during setup", 32'(bus_addr), 32'(a));
        check(data_ok, "R9 write data during setup", 32'(bus_data_out), 32'(wd));
        check(strobes() == exp_strobes(io, wr), "R4 strobe select",
              32'(strobes()), 32'(exp_strobes(io, wr)));
        // command phase
        n = 0; addr_ok = 1'b1;
        while (strobes() != 4'b1111 && n < 200) begin
            if (!noack && n == dly) begin
                xack_n = 1'b0;
                bus_data_in = rd;
            end
            if (bus_addr !== a) addr_ok = 1'b0;
            n++;
            @(negedge clk);
        end
        if (noack)
            check(n == TMO, "R8 timeout length", 32'(n), 32'(TMO));
        else
            check(n == dly + 3, "R5 command length", 32'(n), 32'(dly + 3));
        check(addr_ok, "R9 address during strobe", 32'(bus_addr), 32'(a));
        // hold phase
        n = 0; addr_ok = 1'b1;
        while (!rsp_done && strobes() == 4'b1111 && n < 200) begin
            if (bus_addr !== a) addr_ok = 1'b0;
            n++;
            @(negedge clk);
        end
        check(n == exp_cycles(HLD_NS), "R7 hold length", 32'(n), 32'(exp_cycles(HLD_NS)));
        check(addr_ok, "R7 address during hold", 32'(bus_addr), 32'(a));
        check(rsp_done == 1'b1, "R7 done after hold", 32'(rsp_done), 1);
        if (noack)
            check(rsp_err == 1'b1, "R8 error flag", 32'(rsp_err), 1);
        else
            check(rsp_err == 1'b0, "R10 no error", 32'(rsp_err), 0);
        if (!wr && !noack)
            check(rsp_rdata == rd, "R6 read word", 32'(rsp_rdata), 32'(rd));
        xack_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_done == 1'b0, "R10 single done", 32'(rsp_done), 0);
        check(req_ready == 1'b1, "R2 back to idle", 32'(req_ready), 1);
        if (junk)
            check(bus_addr == a, "R2 busy request ignored", 32'(bus_addr), 32'(a));
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(strobes() == 4'b1111, "R1 strobes in reset", 32'(strobes()), 32'hf);
        rst_n = 1'b1;
        @(negedge clk);
        check(strobes() == 4'b1111, "R1 strobes idle", 32'(strobes()), 32'hf);
        check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
        check(rsp_done == 1'b0, "R1 done low", 32'(rsp_done), 0);
        check(bus_data_oe == 1'b0, "R1 oe low", 32'(bus_data_oe), 0);
        // directed corners
        xfer(16'h1234, 16'hbeef, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        xfer(16'h00ff, 16'ha5a5, 1'b0, 1'b1, 0, 1'b0, 1'b0);
        xfer(16'hf00d, 16'h0001, 1'b1, 1'b0, 7, 1'b0, 1'b0);
        xfer(16'h8001, 16'h7e7e, 1'b1, 1'b1, 2, 1'b0, 1'b1);
        xfer(16'h4444, 16'h0000, 1'b0, 1'b0, 0, 1'b1, 1'b0);
        xfer(16'h5555, 16'hcafe, 1'b1, 1'b1, 0, 1'b1, 1'b1);
        // random transfers
        for (int i = 0; i < 40; i++) begin
            xfer(AW'($urandom), DW'($urandom), 1'($urandom), 1'($urandom),
                 int'($urandom_range(0, 12)), 1'b0, 1'($urandom_range(0, 3) == 0));
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule